// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address that an SDRAM device model or a memory controller needs on each beat of a read or write burst. It holds a decoded copy of the 12-bit mode-register op-code. That copy sets the burst length, the beat ordering and whether writes are forced to a single location. For every burst-start strobe, the block walks through the columns of the burst and emits one column per clock. Each column comes with a valid flag, an auto-precharge flag and a flag marking the final beat.

For fixed lengths of 2, 4 and 8, the upper column bits pick an aligned block. The walk stays inside that block, either incrementing with wrap-around or XOR-ing the start offset with the beat number. In full-page mode the walk runs through the whole row, wraps past the top column and only stops on a terminate strobe or a new burst. A new burst may be issued on any clock and restarts the walk at once.

A mode load that arrives while a burst is running is dropped, and a sticky error flag records it.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is applied and on release, col_valid, last_beat, ap_flag and mode_err are 0. The mode held after reset is length 1, sequential, write-single off.
- R2: Op-code bits [2:0] set the burst length: 000=1, 001=2, 010=4, 011=8 and 111=full page. The codes 100, 101 and 110 give a single beat. A burst_start sampled at clock edge E puts beat 0 on col_out at edge E+1, and beat i at edge E+1+i.
- R3: With op bit [3]=0 (sequential) and length L in {2,4,8}, beat i is at column (start − start mod L) + ((start mod L + i) mod L).
- R4: With op bit [3]=1 (interleaved) and length L in {2,4,8}, beat i is at column (start − start mod L) + ((start mod L) XOR i). For length 1, bit [3] has no effect. Full page with bit [3]=1 gives a single beat.
- R5: In full-page mode, beat i is at column (start + i) mod 2^COL_W. The burst never raises last_beat and runs until a terminate or a new start.
- R6: With op bit [9]=1, a burst whose burst_write is 1 has one beat whatever the length. A burst whose burst_write is 0 keeps the programmed length.
- R7: For a fixed-length burst, last_beat is 1 on the final beat only. col_valid is 0 on the next clock unless a new start was sampled.
- R8: ap_flag equals the burst_ap value sampled with the burst's start, on every beat of that burst. A later start with burst_ap=0 clears it. ap_flag is 0 whenever col_valid is 0.
- R9: A burst_start sampled while a burst is active aborts that burst, and the next beat is beat 0 of the new burst. A burst_start wins over a burst_stop sampled on the same edge.
- R10: A burst_stop sampled without burst_start makes col_valid, last_beat and ap_flag 0 after that edge.
- R11: A mode_load sampled while col_valid is 1 leaves the mode unchanged and sets mode_err, which then stays 1 until reset. A mode_load sampled while idle sets the mode used by every burst_start sampled at a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Load the mode op-code |
| mode_op | input | 12 | Mode op-code |
| burst_start | input | 1 | Start a burst (read or write command) |
| burst_write | input | 1 | 1 for a write burst, 0 for a read |
| burst_col | input | COL_W | Starting column |
| burst_ap | input | 1 | Auto-precharge request for this burst |
| burst_stop | input | 1 | Terminate the current burst |
| col_out | output | COL_W | Column for the current beat |
| col_valid | output | 1 | A beat is presented |
| ap_flag | output | 1 | Current burst requested auto precharge |
| last_beat | output | 1 | Final beat of a fixed-length burst |
| mode_err | output | 1 | Sticky: a mode load was dropped during a burst |

## Verification
The assertions cover the properties that hold on every cycle:
- a start yields beat 0 at the given column on the next clock;
- a stop or a final beat drops col_valid;
- ap_flag never rises without a start and never shows outside a burst;
- a dropped mode load sets the sticky error and leaves the mode untouched.

Only the bench scenarios can show the actual column orders. These are sequential and interleaved wrapping inside 2-, 4- and 8-column blocks, and the full-page wrap past the top column. The scenarios also cover the reserved length codes, the write-single rule, and whether a dropped mode load really left the next burst's length unchanged.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  localparam int OP_W = 12;

  // Decoded mode: what the walk needs, nothing more
  typedef struct packed {
    logic [1:0] len_log2;   // fixed length = 2**len_log2
    logic       full;       // full-page walk
    logic       inter;      // XOR ordering
    logic       wr_single;  // writes forced to one beat
  } bmode_t;

  function automatic bmode_t decode_op(input logic [OP_W-1:0] op);
    bmode_t m;
    m.len_log2  = 2'd0;
    m.full      = 1'b0;
    m.inter     = op[3];
    m.wr_single = op[9];
    case (op[2:0])
      3'b000:  m.len_log2 = 2'd0;
      3'b001:  m.len_log2 = 2'd1;
      3'b010:  m.len_log2 = 2'd2;
      3'b011:  m.len_log2 = 2'd3;
      3'b111:  m.full = ~op[3];   // full page with XOR order: single beat
      default: m.len_log2 = 2'd0; // reserved codes: single beat
    endcase
    return m;
  endfunction

endpackage

// File: rtl/colgen_rst_sync.sv
module colgen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
  import colgen_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            busy,
  input  logic [OP_W-1:0] op,
  output bmode_t          mode,
  output logic            err
);

  logic   mode_en;
  bmode_t mode_d;
  logic   err_d;

  always_comb begin
    mode_en = load & ~busy;
    mode_d  = decode_op(op);
    err_d   = err | (load & busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      err  <= 1'b0;
    end else begin
      if (mode_en) mode <= mode_d;
      err <= err_d;
    end
  end

  // R11: a load during a burst is dropped and flagged
  assert_busy_load_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy) |=> (err && $stable(mode)));

  // R11: the error flag is sticky
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic [COL_W-1:0] col_in,
  input  logic             ap_in,
  input  logic             stop,
  input  bmode_t           mode,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] beat_q,
  output logic [COL_W-1:0] mask_q,
  output logic             inter_q,
  output logic             valid_q,
  output logic             ap_q,
  output logic             last
);

  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             single_wr;
  logic [COL_W-1:0] mask_d;
  logic             full_d;
  logic             full_q;
  logic             at_end;
  logic             valid_d, ap_d;
  logic [COL_W-1:0] beat_d;
  logic             cap_en, run_en;

  always_comb begin
    single_wr = is_write & mode.wr_single;
    full_d    = mode.full & ~single_wr;
    if (single_wr)      mask_d = '0;
    else if (mode.full) mask_d = '1;
    else                mask_d = (ONE << mode.len_log2) - ONE;

    at_end = ~full_q & (beat_q == mask_q);
    cap_en = start;
    run_en = ~start & valid_q;

    valid_d = valid_q;
    ap_d    = ap_q;
    beat_d  = beat_q;
    if (start) begin
      valid_d = 1'b1;
      ap_d    = ap_in;
      beat_d  = '0;
    end else if (valid_q) begin
      if (stop || at_end) begin
        valid_d = 1'b0;
        ap_d    = 1'b0;
      end else begin
        beat_d = beat_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ap_q    <= 1'b0;
      beat_q  <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      inter_q <= 1'b0;
    end else begin
      if (cap_en || run_en) begin
        valid_q <= valid_d;
        ap_q    <= ap_d;
        beat_q  <= beat_d;
      end
      if (cap_en) begin
        base_q  <= col_in;
        mask_q  <= mask_d;
        full_q  <= full_d;
        inter_q <= mode.inter;
      end
    end
  end

  assign last = valid_q & at_end;

  // R10: a stop without a start ends the burst
  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !valid_q);

  // R7: nothing follows the final beat unless restarted
  assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !valid_q);

  // R9: a start always yields beat 0 next
  assert_start_beat0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (valid_q && beat_q == '0));

  // R5: a full-page walk never runs out on its own
  assert_full_no_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && full_q && !stop) |=> valid_q);

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             inter,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] seq_idx;
  logic [COL_W-1:0] xor_idx;
  logic [COL_W-1:0] sel_idx;

  always_comb begin
    seq_idx = base + beat;
    xor_idx = base ^ beat;
    sel_idx = inter ? xor_idx : seq_idx;
  end

  // Bits inside the block walk; bits above it keep the block number
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col[b] = mask[b] ? sel_idx[b] : base[b];
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [11:0]      mode_op,
  input  logic             burst_start,
  input  logic             burst_write,
  input  logic [COL_W-1:0] burst_col,
  input  logic             burst_ap,
  input  logic             burst_stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             ap_flag,
  output logic             last_beat,
  output logic             mode_err
);

  logic             rst_n_s;
  bmode_t           mode;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic             inter_q, valid_q, ap_q, last;

  colgen_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  colgen_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n_s), .load(mode_load), .busy(valid_q),
    .op(mode_op), .mode(mode), .err(mode_err)
  );

  colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk(clk), .rst_n(rst_n_s), .start(burst_start), .is_write(burst_write),
    .col_in(burst_col), .ap_in(burst_ap), .stop(burst_stop), .mode(mode),
    .base_q(base_q), .beat_q(beat_q), .mask_q(mask_q), .inter_q(inter_q),
    .valid_q(valid_q), .ap_q(ap_q), .last(last)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .base(base_q), .beat(beat_q), .mask(mask_q), .inter(inter_q), .col(col_out)
  );

  assign col_valid = valid_q;
  assign ap_flag   = valid_q & ap_q;
  assign last_beat = last;

  // R9: beat 0 presents the requested column
  assert_start_col_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    burst_start |=> (col_valid && col_out == $past(burst_col)));

  // R8: ap_flag only within a burst
  assert_ap_in_burst_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    ap_flag |-> col_valid);

  // R8: ap_flag cannot rise without a start
  assert_ap_no_rise_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !burst_start |=> (!ap_flag || $past(ap_flag)));

  // R7: last_beat only on a presented beat
  assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    last_beat |-> col_valid);

endmodule

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;

  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             mode_load;
  logic [11:0]      mode_op;
  logic             burst_start, burst_write, burst_ap, burst_stop;
  logic [COL_W-1:0] burst_col;
  logic [COL_W-1:0] col_out;
  logic             col_valid, ap_flag, last_beat, mode_err;

  always #5 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_op(mode_op),
    .burst_start(burst_start), .burst_write(burst_write), .burst_col(burst_col),
    .burst_ap(burst_ap), .burst_stop(burst_stop), .col_out(col_out),
    .col_valid(col_valid), .ap_flag(ap_flag), .last_beat(last_beat),
    .mode_err(mode_err)
  );

  typedef struct packed {
    logic             v;
    logic [COL_W-1:0] c;
    logic             ap;
    logic             last;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks   = 0;
  int    failures = 0;

  // Op-code: [9] write-single, [6:4] latency (2), [3] XOR order, [2:0] length
  function automatic logic [11:0] mop(input logic [2:0] len, input logic t, input logic ws);
    return {2'b00, ws, 2'b00, 3'b010, t, len};
  endfunction

  function automatic logic [COL_W-1:0] ecol(input int c, input int blk, input bit inter,
                                            input bit full, input int i);
    int base, off;
    if (full) return COL_W'((c + i) % PAGE);
    base = c - (c % blk);
    off  = c % blk;
    if (inter) return COL_W'(base + (off ^ i));
    return COL_W'(base + ((off + i) % blk));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(col_valid == e.v, {t, " valid"}, int'(col_valid), int'(e.v));
      chk(ap_flag == e.ap, {t, " ap"}, int'(ap_flag), int'(e.ap));
      chk(last_beat == e.last, {t, " last"}, int'(last_beat), int'(e.last));
      if (e.v) chk(col_out == e.c, {t, " col"}, int'(col_out), int'(e.c));
    end
  end

  task automatic push(input exp_t e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // Wait one edge, release strobes, queue expectation for that edge
  task automatic idle_tick(input string t);
    exp_t e;
    @(posedge clk); #1;
    burst_start = 0; burst_stop = 0; mode_load = 0;
    e = '0;
    push(e, t);
  endtask

  task automatic do_burst(input int c, input bit wr, input bit ap, input int blk,
                          input bit inter, input bit full, input int nb, input int i0,
                          input int obs, input bit go, input string t);
    if (go) begin
      burst_col = COL_W'(c); burst_write = wr; burst_ap = ap; burst_start = 1;
    end
    for (int k = 0; k < obs; k++) begin
      int   i;
      bit   v;
      exp_t e;
      i = i0 + k;
      v = full || (i < nb);
      @(posedge clk); #1;
      burst_start = 0; burst_stop = 0; mode_load = 0;
      e.v    = v;
      e.c    = v ? ecol(c, blk, inter, full, i) : '0;
      e.ap   = v & ap;
      e.last = v & !full & (i == nb - 1);
      push(e, t);
    end
  endtask

  task automatic load_mode(input logic [11:0] op, input string t);
    mode_load = 1; mode_op = op;
    idle_tick(t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; mode_load = 0; mode_op = '0; burst_start = 0; burst_write = 0;
    burst_col = '0; burst_ap = 0; burst_stop = 0;
    repeat (3) @(posedge clk); #1;
    chk(!col_valid && !last_beat && !ap_flag && !mode_err, "R1 reset outputs",
        int'({col_valid, last_beat, ap_flag, mode_err}), 0);
    rst_n = 1;
    repeat (3) @(posedge clk); #1;
    chk(!col_valid && !mode_err, "R1 after release", int'({col_valid, mode_err}), 0);

    // R1: reset mode is a single-beat burst
    do_burst(37, 0, 0, 1, 0, 0, 1, 0, 2, 1, "R1 reset mode single");

    // R3 R2 R7: length 8 sequential from offset 5
    load_mode(mop(3'b011, 0, 0), "R11 idle load");
    do_burst(13, 0, 0, 8, 0, 0, 8, 0, 9, 1, "R3 seq8");

    // R4 R8: length 8 interleaved, 5-4-7-6-1-0-3-2, with auto precharge
    load_mode(mop(3'b011, 1, 0), "R11 idle load");
    do_burst(69, 0, 1, 8, 1, 0, 8, 0, 9, 1, "R4 int8");

    // R2: length 4 sequential, length 2 interleaved
    load_mode(mop(3'b010, 0, 0), "R11 idle load");
    do_burst(6, 1, 0, 4, 0, 0, 4, 0, 5, 1, "R2 seq4");
    load_mode(mop(3'b001, 1, 0), "R11 idle load");
    do_burst(3, 0, 0, 2, 1, 0, 2, 0, 3, 1, "R2 int2");

    // R2: reserved length code gives a single beat
    load_mode(mop(3'b101, 0, 0), "R11 idle load");
    do_burst(100, 0, 0, 1, 0, 0, 1, 0, 2, 1, "R2 reserved len");

    // R4: length 1 ignores order bit
    load_mode(mop(3'b000, 1, 0), "R11 idle load");
    do_burst(77, 0, 1, 1, 0, 0, 1, 0, 2, 1, "R4 len1 xor");

    // R5 R10: full page wraps past the top column, then stopped
    load_mode(mop(3'b111, 0, 0), "R11 idle load");
    do_burst(509, 0, 1, 1, 0, 1, 0, 0, 6, 1, "R5 full page");
    burst_stop = 1;
    idle_tick("R10 stop full page");

    // R4: full page with XOR order gives a single beat
    load_mode(mop(3'b111, 1, 0), "R11 idle load");
    do_burst(200, 0, 0, 1, 0, 0, 1, 0, 2, 1, "R4 full xor reserved");

    // R6: write-single affects writes only
    load_mode(mop(3'b010, 0, 1), "R11 idle load");
    do_burst(10, 1, 0, 1, 0, 0, 1, 0, 2, 1, "R6 write single");
    do_burst(10, 0, 0, 4, 0, 0, 4, 0, 5, 1, "R6 read keeps length");

    // R9 R8: restart mid-burst, new burst clears ap
    load_mode(mop(3'b011, 0, 0), "R11 idle load");
    do_burst(0, 0, 1, 8, 0, 0, 8, 0, 3, 1, "R9 first burst");
    do_burst(20, 0, 0, 8, 0, 0, 8, 0, 9, 1, "R9 restart");

    // R9: start wins over stop on the same edge
    burst_stop = 1;
    do_burst(50, 0, 0, 8, 0, 0, 8, 0, 9, 1, "R9 start over stop");

    // R10: stop in the middle of a fixed burst
    do_burst(33, 1, 1, 8, 0, 0, 8, 0, 2, 1, "R10 before stop");
    burst_stop = 1;
    idle_tick("R10 stop fixed");
    chk(!mode_err, "R11 no error yet", int'(mode_err), 0);

    // R11: load during a burst is dropped and flagged
    do_burst(40, 0, 0, 8, 0, 0, 8, 0, 2, 1, "R11 busy burst");
    mode_load = 1; mode_op = mop(3'b001, 0, 0);
    do_burst(40, 0, 0, 8, 0, 0, 8, 2, 1, 0, "R11 busy load");
    chk(mode_err, "R11 error set", int'(mode_err), 1);
    do_burst(40, 0, 0, 8, 0, 0, 8, 3, 6, 0, "R11 busy continue");
    do_burst(41, 0, 0, 8, 0, 0, 8, 0, 9, 1, "R11 mode kept");
    idle_tick("R11 idle");
    chk(mode_err, "R11 error sticky", int'(mode_err), 1);

    idle_tick("R7 drain");
    @(posedge clk); #1;
    chk(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule